// File: doc/BRIEF.md
# Two-Channel PWM Output Action Stage

This block turns counter events from a PWM time base into the output levels of two channels, A and B. On every prescaled clock tick it looks at four event strobes (counter at zero, counter at period, counter rising through compare A, counter rising through compare B). Each channel has its own action register, with a 2-bit code per event that leaves the output alone, drives it low, drives it high or toggles it. Software chooses the waveform through these codes. Setting on zero and period and clearing on the compare gives an active-high duty cycle, and the mirrored codes give the inverted one.

Software can also hold either output at a fixed level with a continuous force. A write to the force register lands in a shadow copy first. The copy becomes active at a reload point that software picks: counter zero, counter period, either of them, or the next tick. While a force is active it overrides every event action on its channel. Configuration arrives through a 16-bit write port with a 2-bit register select.

Top module: `pwm_action_qualifier`

## Requirements
- R1: After reset both outputs are low, both action registers hold all no-change codes, and the force shadow, the active force and the reload mode are all zero. With every event strobed, both outputs stay low until software writes.
- R2: A write with `wr_addr` 0 loads the channel A action register and `wr_addr` 1 loads channel B. `wr_addr` 2 loads the force register. A write to `wr_addr` 3 changes nothing. In an action register, the zero action is in bits 1:0, the period action in bits 3:2, the compare-A-up action in bits 5:4 and the compare-B-up action in bits 9:8.
- R3: The action codes are 00 no change, 01 drive low, 10 drive high and 11 toggle. The chosen action is applied on the tick that carries the event.
- R4: Events and forces act only in cycles where `tick` is 1. With `tick` at 0, both outputs hold whatever the event inputs do.
- R5: When several events arrive on one tick, only the highest-priority event whose code is not 00 acts. The order from highest to lowest is compare-B-up, compare-A-up, period, zero. An event whose code is 00 does not block a lower-priority one.
- R6: In the force register, bits 1:0 set channel A and bits 3:2 set channel B. In each field, 00 means no force, 01 forces low, 10 forces high and 11 disables forcing, which behaves like 00.
- R7: While a channel's active force is low or high, its output takes that level on every tick, whatever events arrive.
- R8: Force register bits 7:6 select the reload mode, which takes effect as soon as it is written. A written force value stays in the shadow until a tick that meets the mode: 00 needs a zero event, 01 a period event, 10 either of them. The written value does not change the output before then.
- R9: In reload mode 11 the shadowed force becomes active on the next tick, and the forced level is on the output just after that tick.
- R10: Action registers for channel A set to 0x001A, and for channel B set to 0x010A, give outputs that go high on zero or period and low on their own compare-up event. The values 0x0025 and 0x0205 give the inverted waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Prescaled time-base clock enable |
| evt_zero | input | 1 | Counter equals zero |
| evt_period | input | 1 | Counter equals period |
| evt_cmpa_up | input | 1 | Counter reached compare A while counting up |
| evt_cmpb_up | input | 1 | Counter reached compare B while counting up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 action A, 1 action B, 2 force) |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | Channel A output level |
| pwm_b | output | 1 | Channel B output level |

## Verification
On every cycle the assertions check four things. Outputs and active force hold when there is no tick. A low or high force shows on the output after each tick. The active force does not move outside its reload point. Immediate mode copies the shadow on the tick. The bench runs the scenarios that need expected levels. It sweeps every action code on every event for both channels and all sixteen event combinations for the priority order. It crosses force values with all four reload modes, tries the unused address, and plays both polarity programs as a waveform.

// File: rtl/aq_pkg.sv
package aq_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } aq_act_e;

  typedef enum logic [1:0] {
    RLD_AT_ZERO   = 2'b00,
    RLD_AT_PERIOD = 2'b01,
    RLD_AT_EITHER = 2'b10,
    RLD_AT_ONCE   = 2'b11
  } aq_reload_e;

  localparam logic [1:0] FRC_LOW  = 2'b01;
  localparam logic [1:0] FRC_HIGH = 2'b10;

  typedef struct packed {
    logic cmpb_up;
    logic cmpa_up;
    logic period;
    logic zero;
  } aq_evt_t;

  typedef struct packed {
    aq_act_e on_cmpb;
    aq_act_e on_cmpa;
    aq_act_e on_period;
    aq_act_e on_zero;
  } aq_ctl_t;

  // field positions inside the action register
  localparam int CTL_ZERO_LSB = 0;
  localparam int CTL_PRD_LSB  = 2;
  localparam int CTL_CMPA_LSB = 4;
  localparam int CTL_CMPB_LSB = 8;
  // reload mode position inside the force register
  localparam int FRC_MODE_LSB = 6;

  // register select values
  localparam logic [1:0] ADDR_CTL_BASE = 2'd0;
  localparam logic [1:0] ADDR_FORCE    = 2'd2;

endpackage

// File: rtl/aq_rst_sync.sv
module aq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/aq_force_ctrl.sv
module aq_force_ctrl import aq_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_hit,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  tick,
  input  aq_evt_t               evt,
  output logic [2*NUM_CH-1:0]   shadow_q,
  output logic [2*NUM_CH-1:0]   act_q,
  output logic [2*NUM_CH-1:0]   act_nxt,
  output aq_reload_e            mode_q
);
  localparam int FW = 2 * NUM_CH;

  logic [FW-1:0] shadow_nxt;
  aq_reload_e    mode_nxt;
  logic          load_pt;
  logic          unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[DATA_W-1:FRC_MODE_LSB+2], wr_data[FRC_MODE_LSB-1:FW]};

  // shadow and mode next state
  always_comb begin
    shadow_nxt = shadow_q;
    mode_nxt   = mode_q;
    if (wr_hit) begin
      shadow_nxt = wr_data[FW-1:0];
      mode_nxt   = aq_reload_e'(wr_data[FRC_MODE_LSB +: 2]);
    end
  end

  // reload point decode
  always_comb begin
    case (mode_q)
      RLD_AT_ZERO:   load_pt = evt.zero;
      RLD_AT_PERIOD: load_pt = evt.period;
      RLD_AT_EITHER: load_pt = evt.zero | evt.period;
      default:       load_pt = 1'b1;
    endcase
  end

  assign act_nxt = (tick && load_pt) ? shadow_q : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      mode_q   <= RLD_AT_ZERO;
      act_q    <= '0;
    end else begin
      shadow_q <= shadow_nxt;
      mode_q   <= mode_nxt;
      if (tick) act_q <= act_nxt;
    end
  end
endmodule

// File: rtl/aq_channel.sv
module aq_channel import aq_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  input  aq_evt_t           evt,
  input  logic [1:0]        force_code,
  output logic              lvl_q
);
  aq_ctl_t ctl_q, ctl_nxt;
  aq_act_e sel_act;
  logic    evt_lvl;
  logic    lvl_nxt;
  logic    unused_ctl_bits;

  assign unused_ctl_bits = ^{wr_data[DATA_W-1:CTL_CMPB_LSB+2], wr_data[CTL_CMPB_LSB-1:CTL_CMPA_LSB+2]};

  always_comb begin
    ctl_nxt = ctl_q;
    if (ctl_we) begin
      ctl_nxt.on_zero   = aq_act_e'(wr_data[CTL_ZERO_LSB +: 2]);
      ctl_nxt.on_period = aq_act_e'(wr_data[CTL_PRD_LSB  +: 2]);
      ctl_nxt.on_cmpa   = aq_act_e'(wr_data[CTL_CMPA_LSB +: 2]);
      ctl_nxt.on_cmpb   = aq_act_e'(wr_data[CTL_CMPB_LSB +: 2]);
    end
  end

  // later assignments carry higher priority; keep codes never mask
  always_comb begin
    sel_act = ACT_KEEP;
    if (evt.zero    && ctl_q.on_zero   != ACT_KEEP) sel_act = ctl_q.on_zero;
    if (evt.period  && ctl_q.on_period != ACT_KEEP) sel_act = ctl_q.on_period;
    if (evt.cmpa_up && ctl_q.on_cmpa   != ACT_KEEP) sel_act = ctl_q.on_cmpa;
    if (evt.cmpb_up && ctl_q.on_cmpb   != ACT_KEEP) sel_act = ctl_q.on_cmpb;
  end

  always_comb begin
    case (sel_act)
      ACT_LOW:    evt_lvl = 1'b0;
      ACT_HIGH:   evt_lvl = 1'b1;
      ACT_TOGGLE: evt_lvl = ~lvl_q;
      default:    evt_lvl = lvl_q;
    endcase
  end

  always_comb begin
    lvl_nxt = lvl_q;
    if (tick) begin
      if (force_code == FRC_LOW)       lvl_nxt = 1'b0;
      else if (force_code == FRC_HIGH) lvl_nxt = 1'b1;
      else                             lvl_nxt = evt_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{default: ACT_KEEP};
      lvl_q <= 1'b0;
    end else begin
      ctl_q <= ctl_nxt;
      if (tick) lvl_q <= lvl_nxt;
    end
  end
endmodule

// File: rtl/pwm_action_qualifier.sv
module pwm_action_qualifier import aq_pkg::*; #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              evt_zero,
  input  logic              evt_period,
  input  logic              evt_cmpa_up,
  input  logic              evt_cmpb_up,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_a,
  output logic              pwm_b
);
  localparam int NUM_CH = 2;
  localparam int FW     = 2 * NUM_CH;

  logic          rst_sync_n;
  aq_evt_t       evt;
  logic [FW-1:0] force_shadow;
  logic [FW-1:0] force_act;
  logic [FW-1:0] force_nxt;
  aq_reload_e    reload_mode;
  logic          force_hit;
  logic [NUM_CH-1:0] lvl;

  aq_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign evt       = '{cmpb_up: evt_cmpb_up, cmpa_up: evt_cmpa_up,
                       period: evt_period, zero: evt_zero};
  assign force_hit = wr_en && (wr_addr == ADDR_W'(ADDR_FORCE));

  aq_force_ctrl #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) force_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_hit   (force_hit),
    .wr_data  (wr_data),
    .tick     (tick),
    .evt      (evt),
    .shadow_q (force_shadow),
    .act_q    (force_act),
    .act_nxt  (force_nxt),
    .mode_q   (reload_mode)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic ctl_we;
    assign ctl_we = wr_en && (wr_addr == ADDR_W'(ADDR_CTL_BASE) + ADDR_W'(ch));
    aq_channel #(.DATA_W(DATA_W)) chan_i (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .ctl_we     (ctl_we),
      .wr_data    (wr_data),
      .tick       (tick),
      .evt        (evt),
      .force_code (force_nxt[2*ch +: 2]),
      .lvl_q      (lvl[ch])
    );
  end

  assign pwm_a = lvl[0];
  assign pwm_b = lvl[1];
endmodule

// File: rtl/pwm_action_qualifier_chk.sv
module pwm_action_qualifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       evt_zero,
  input logic       evt_period,
  input logic [1:0] mode,
  input logic [3:0] shadow,
  input logic [3:0] act,
  input logic       pwm_a,
  input logic       pwm_b
);
  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pwm_a) && $stable(pwm_b) && $stable(act)));

  assert_force_low_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((act[1:0] != 2'b01) || !pwm_a));
  assert_force_high_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((act[1:0] != 2'b10) || pwm_a));
  assert_force_low_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((act[3:2] != 2'b01) || !pwm_b));
  assert_force_high_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((act[3:2] != 2'b10) || pwm_b));

  assert_wait_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'b00 && !evt_zero) |=> $stable(act));
  assert_wait_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'b01 && !evt_period) |=> $stable(act));
  assert_wait_either_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'b10 && !evt_zero && !evt_period) |=> $stable(act));

  assert_load_now_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'b11) |=> (act == $past(shadow)));
endmodule

bind pwm_action_qualifier pwm_action_qualifier_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tick       (tick),
  .evt_zero   (evt_zero),
  .evt_period (evt_period),
  .mode       (reload_mode),
  .shadow     (force_shadow),
  .act        (force_act),
  .pwm_a      (pwm_a),
  .pwm_b      (pwm_b)
);

// File: tb/pwm_action_qualifier_tb_top.sv
module pwm_action_qualifier_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, tick, ez, ep, eca, ecb, wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        pwm_a, pwm_b;

  int n_vec = 0;
  int n_bad = 0;

  // behavioural model state
  logic [15:0] m_ctl [2];
  logic [1:0]  m_sh  [2];
  logic [1:0]  m_act [2];
  logic [1:0]  m_mode;
  logic        m_out [2];

  pwm_action_qualifier dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .evt_zero(ez), .evt_period(ep), .evt_cmpa_up(eca), .evt_cmpb_up(ecb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  function automatic logic ref_level(logic cur, logic [15:0] ctl, logic [1:0] frc,
                                     logic z, logic p, logic a, logic b);
    logic [1:0] code;
    if (frc == 2'b01) return 1'b0;
    if (frc == 2'b10) return 1'b1;
    code = 2'b00;
    if (z && ctl[1:0] != 2'b00) code = ctl[1:0];
    if (p && ctl[3:2] != 2'b00) code = ctl[3:2];
    if (a && ctl[5:4] != 2'b00) code = ctl[5:4];
    if (b && ctl[9:8] != 2'b00) code = ctl[9:8];
    case (code)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic chk(string req, logic act_v, logic exp_v, string what);
    n_vec++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act_v, exp_v);
    end
  endtask

  task automatic check_both(string req);
    chk(req, pwm_a, m_out[0], "pwm_a");
    chk(req, pwm_b, m_out[1], "pwm_b");
  endtask

  task automatic wr(logic [1:0] addr, logic [15:0] data);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr < 2) m_ctl[addr] = data;
    else if (addr == 2) begin
      m_sh[0] = data[1:0];
      m_sh[1] = data[3:2];
      m_mode  = data[7:6];
    end
  endtask

  task automatic step(string req, logic z, logic p, logic a, logic b);
    logic load;
    tick = 1'b1; ez = z; ep = p; eca = a; ecb = b;
    @(negedge clk);
    tick = 1'b0; ez = 0; ep = 0; eca = 0; ecb = 0;
    case (m_mode)
      2'd0:    load = z;
      2'd1:    load = p;
      2'd2:    load = z | p;
      default: load = 1'b1;
    endcase
    if (load) begin
      m_act[0] = m_sh[0];
      m_act[1] = m_sh[1];
    end
    for (int ch = 0; ch < 2; ch++)
      m_out[ch] = ref_level(m_out[ch], m_ctl[ch], m_act[ch], z, p, a, b);
    check_both(req);
  endtask

  task automatic idle_events(logic [3:0] ev);
    tick = 1'b0; ez = ev[0]; ep = ev[1]; eca = ev[2]; ecb = ev[3];
    @(negedge clk);
    ez = 0; ep = 0; eca = 0; ecb = 0;
    check_both("R4");
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 0; ez = 0; ep = 0; eca = 0; ecb = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0;
    for (int ch = 0; ch < 2; ch++) begin
      m_ctl[ch] = 16'h0; m_sh[ch] = 2'b00; m_act[ch] = 2'b00; m_out[ch] = 1'b0;
    end
    m_mode = 2'b00;
    repeat (3) @(negedge clk);
    check_both("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_both("R1");
    // R1: nothing programmed, every event leaves the outputs low
    step("R1", 1, 1, 1, 1);
    step("R1", 1, 0, 0, 0);

    // R2 / R3: every code on every event field, both channels
    for (int ev = 0; ev < 4; ev++) begin
      for (int code = 0; code < 4; code++) begin
        int pos;
        pos = (ev == 3) ? 8 : 2 * ev;
        wr(2'd0, 16'(code) << pos);
        wr(2'd1, 16'(3 - code) << pos);
        for (int rep = 0; rep < 2; rep++)
          step("R3", ev == 0, ev == 1, ev == 2, ev == 3);
        // other events must not use this field
        step("R2", ev != 0, ev != 1, ev != 2, ev != 3);
      end
    end

    // R2: write to unused select changes nothing
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'h0300);
    wr(2'd3, 16'hFFFF);
    step("R2", 1, 0, 0, 0);
    step("R2", 0, 0, 0, 1);
    step("R2", 1, 1, 1, 1);

    // R4: events without a tick
    for (int ev = 1; ev < 16; ev++) idle_events(4'(ev));

    // R5: all event combinations under two priority programs
    wr(2'd0, 16'h0100 | 16'h0020 | 16'h000C | 16'h0002);
    wr(2'd1, 16'h0010 | 16'h0002);
    for (int rep = 0; rep < 2; rep++)
      for (int ev = 0; ev < 16; ev++) begin
        step("R5", 1'b0, 1'b0, 1'b0, 1'b0);
        step("R5", ev[0], ev[1], ev[2], ev[3]);
      end

    // R6..R9: force values across reload modes
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'h000C);
    for (int md = 0; md < 4; md++) begin
      for (int f = 0; f < 4; f++) begin
        wr(2'd2, 16'((md << 6) | ((3 - f) << 2) | f));
        step(md == 3 ? "R9" : "R8", 0, 0, 0, 0);
        step("R8", 0, 1, 0, 0);
        step("R7", 1, 0, 0, 0);
        step("R6", 1, 1, 0, 0);
      end
      wr(2'd2, 16'(md << 6));
      step("R8", 1, 1, 0, 0);
      step("R8", 1, 0, 0, 0);
    end

    // R10: normal then inverted polarity waveform
    wr(2'd2, 16'h00C0);
    step("R10", 0, 0, 0, 0);
    for (int pol = 0; pol < 2; pol++) begin
      wr(2'd0, pol == 0 ? 16'h001A : 16'h0025);
      wr(2'd1, pol == 0 ? 16'h010A : 16'h0205);
      for (int per = 0; per < 3; per++) begin
        step("R10", 1, 0, 0, 0);
        step("R10", 0, 0, 0, 0);
        step("R10", 0, 0, 1, 0);
        step("R10", 0, 0, 0, 1);
        step("R10", 0, 1, 0, 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule